// File: doc/BRIEF.md
# Shared Dual-Port Program Memory

This block is an instruction store that two agents share. A host reaches it through a 32-bit native RAM port. A bus-to-RAM controller outside the block drives that port, so the host can read program words back or replace them while the system runs. A small soft processor fetches 18-bit instructions through a second port. Each port has its own enable. At power-up the array already holds a program image that is computed from parameters, so the processor runs valid code as soon as reset is released.

Both ports take 32-bit byte addresses and drop the two low bits, which keeps every access word-aligned. Each stored word is 18 bits wide. The host port maps this width onto its 32-bit bus, has byte write enables, and returns the word it has just written on a read to the same address (write-first). The instruction port returns the contents from before a write to the same address (read-first). Both ports share one clock and one synchronous active-low reset.

Top module: `dual_port_prog_mem`

## Requirements
- R1: At power-up, word i holds (i*BOOT_MUL + BOOT_ADD) mod 2^18. The defaults are 37 and 5. Either port can read the image without any prior write.
- R2: The word index is address bits [IDX_W+1:2], where IDX_W = log2(DEPTH). Address bits [1:0] and all bits above the index are ignored, so an access past the last word wraps around the array.
- R3: A host read returns the 18-bit stored word in bits [17:0] of `h_rdata`. Bits [31:18] are always zero.
- R4: Host byte enables `h_be` select the bits a write replaces. `h_be[0]` covers bits [7:0], `h_be[1]` covers bits [15:8] and `h_be[2]` covers bits [17:16]. `h_be[3]` touches no stored bit. Stored bits without an active enable keep their old value, and `h_be` = 0 leaves the word unchanged.
- R5: The host port is write-first. In the cycle of a host write, `h_rdata` shows the word as it stands after the byte merge.
- R6: The instruction port is read-first. In the cycle of an instruction-port write, `i_rdata` shows the word as it stood before the write.
- R7: Read data appears on the clock edge that samples the address and enable. There is no further output register.
- R8: While a port's enable is low, that port neither reads nor writes, and its read data holds its last value.
- R9: When `rst_n` is low at a clock edge, both read-data registers clear to zero and no write takes place. The array contents are kept.
- R10: A word written through one port is returned by the other port on its next read of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset of the read registers |
| h_en | input | 1 | Host port enable |
| h_be | input | 4 | Host byte write enables |
| h_addr | input | 32 | Host byte address |
| h_wdata | input | 32 | Host write data, bits [17:0] used |
| h_rdata | output | 32 | Host read data, zero-extended word |
| i_en | input | 1 | Instruction port enable |
| i_we | input | 1 | Instruction port write enable |
| i_addr | input | 32 | Instruction port byte address |
| i_wdata | input | 18 | Instruction port write data |
| i_rdata | output | 18 | Instruction word to the processor |

## Verification
The bench reads every word of a 64-word array through both ports, using byte addresses with stray low bits and stray high bits. A wrong index slice or a missing wrap returns the wrong program word. It applies all sixteen byte-enable patterns to one word. A wrong lane map corrupts bits [17:16] or writes on an empty mask, and a host port that was read-first instead of write-first returns stale data in the write cycle. It also checks four more cases. An instruction-port write with its read must return the old word. A disabled port must neither move its output nor store data. A mid-run reset must clear the outputs and keep the contents. Data written through one port must be seen on the other.

// File: rtl/dpm_pkg.sv
// Package for the shared program memory.
// Holds the fixed widths, the stored word type and the power-up image formula.
// Assumes a word of 18 bits and a host bus of 32 bits.
package dpm_pkg;
    localparam int WORD_W = 18;
    localparam int HOST_W = 32;
    localparam int ADDR_W = 32;
    localparam int BE_W   = HOST_W / 8;

    typedef logic [WORD_W-1:0] word_t;

    // Boot image word for array slot idx.
    function automatic word_t boot_word(int unsigned idx, int unsigned mul, int unsigned add);
        int unsigned v;
        v = idx * mul + add;
        return word_t'(v);
    endfunction
endpackage

// File: rtl/dpm_word_index.sv
// Turns a byte address into a word index.
// Drops the two byte-offset bits and every bit above the index width, so an
// access past the array end wraps. Assumes the depth is a power of two.
module dpm_word_index #(
    parameter int IDX_W = 10
) (
    input  logic [dpm_pkg::ADDR_W-1:0] byte_addr,
    output logic [IDX_W-1:0]           word_idx
);
    localparam int TOP = IDX_W + 2;

    assign word_idx = byte_addr[TOP-1:2];

    generate
        if (TOP < dpm_pkg::ADDR_W) begin : g_high
            logic unused_high;
            assign unused_high = ^{byte_addr[dpm_pkg::ADDR_W-1:TOP], byte_addr[1:0]};
        end else begin : g_nohigh
            logic unused_low;
            assign unused_low = ^byte_addr[1:0];
        end
    endgenerate
endmodule

// File: rtl/dpm_host_lane.sv
// Maps between the host bus and the stored word.
// On the write side it merges enabled byte lanes of the host data into the
// current word. On the read side it zero-extends a stored word onto the bus.
// Assumes that lanes beyond the stored word width carry no storage.
module dpm_host_lane (
    input  logic [dpm_pkg::BE_W-1:0]   be,
    input  logic [dpm_pkg::HOST_W-1:0] wdata,
    input  dpm_pkg::word_t             cur_word,
    output dpm_pkg::word_t             merged_word,
    output logic                       wr,
    input  dpm_pkg::word_t             rd_word,
    output logic [dpm_pkg::HOST_W-1:0] rdata
);
    import dpm_pkg::*;

    localparam int NLANE = (WORD_W + 7) / 8;

    // Any set enable is a write request. Lanes without storage change nothing.
    assign wr = |be;

    genvar g;
    generate
        for (g = 0; g < NLANE; g++) begin : g_lane
            localparam int LO = 8 * g;
            localparam int LW = (WORD_W - LO > 8) ? 8 : (WORD_W - LO);
            // Choose new or old bits for this lane.
            assign merged_word[LO +: LW] = be[g] ? wdata[LO +: LW] : cur_word[LO +: LW];
        end
        if (BE_W > NLANE) begin : g_spare
            logic unused_be;
            assign unused_be = ^be[BE_W-1:NLANE];
        end
    endgenerate

    logic unused_wdata;
    assign unused_wdata = ^wdata[HOST_W-1:WORD_W];

    // Zero-extend the stored word onto the host bus.
    assign rdata = {{(HOST_W - WORD_W){1'b0}}, rd_word};
endmodule

// File: rtl/dpm_core.sv
// Storage array and the two read registers.
// The host side reads write-first and the instruction side reads read-first.
// The array is loaded with the boot image at power-up. Reset clears only the
// read registers. Assumes that both ports never write one word in the same cycle.
module dpm_core #(
    parameter int          DEPTH    = 1024,
    parameter int          IDX_W    = 10,
    parameter int unsigned BOOT_MUL = 37,
    parameter int unsigned BOOT_ADD = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           a_en,
    input  logic           a_wr,
    input  logic [IDX_W-1:0] a_idx,
    input  dpm_pkg::word_t a_wword,
    output dpm_pkg::word_t a_cur,
    output dpm_pkg::word_t a_q,
    input  logic           b_en,
    input  logic           b_wr,
    input  logic [IDX_W-1:0] b_idx,
    input  dpm_pkg::word_t b_wword,
    output dpm_pkg::word_t b_q
);
    import dpm_pkg::*;

    word_t mem [DEPTH];

    // Power-up program image.
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = boot_word(i, BOOT_MUL, BOOT_ADD);
    end

    // Current contents at the host index, used for the byte merge.
    assign a_cur = mem[a_idx];

    // Array writes from both ports, blocked during reset.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            if (a_en && a_wr) mem[a_idx] <= a_wword;
            if (b_en && b_wr) mem[b_idx] <= b_wword;
        end
    end

    // Host read register, write-first.
    always_ff @(posedge clk) begin
        if (!rst_n)    a_q <= '0;
        else if (a_en) a_q <= a_wr ? a_wword : mem[a_idx];
    end

    // Instruction read register, read-first.
    always_ff @(posedge clk) begin
        if (!rst_n)    b_q <= '0;
        else if (b_en) b_q <= mem[b_idx];
    end

    p_hold_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |=> $stable(a_q));
    p_hold_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> $stable(b_q));
    p_wfirst_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_wr && !(b_en && b_wr && b_idx == a_idx)) |=> (a_q == mem[$past(a_idx)]));
    p_store_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && b_wr && !(a_en && a_wr && a_idx == b_idx)) |=> (mem[$past(b_idx)] == $past(b_wword)));
endmodule

// File: rtl/dual_port_prog_mem.sv
// Top of the shared program memory.
// Joins the address slicing, the host width mapping and the storage core.
// Assumes DEPTH is a power of two and that one clock serves both ports.
module dual_port_prog_mem #(
    parameter int          DEPTH    = 1024,
    parameter int unsigned BOOT_MUL = 37,
    parameter int unsigned BOOT_ADD = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        h_en,
    input  logic [3:0]  h_be,
    input  logic [31:0] h_addr,
    input  logic [31:0] h_wdata,
    output logic [31:0] h_rdata,
    input  logic        i_en,
    input  logic        i_we,
    input  logic [31:0] i_addr,
    input  logic [17:0] i_wdata,
    output logic [17:0] i_rdata
);
    import dpm_pkg::*;

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0] h_idx, i_idx;
    word_t h_cur, h_merged, h_q, i_q;
    logic  h_wr;

    dpm_word_index #(.IDX_W(IDX_W)) u_hidx (.byte_addr(h_addr), .word_idx(h_idx));
    dpm_word_index #(.IDX_W(IDX_W)) u_iidx (.byte_addr(i_addr), .word_idx(i_idx));

    dpm_host_lane u_lane (
        .be(h_be), .wdata(h_wdata), .cur_word(h_cur), .merged_word(h_merged),
        .wr(h_wr), .rd_word(h_q), .rdata(h_rdata)
    );

    dpm_core #(.DEPTH(DEPTH), .IDX_W(IDX_W), .BOOT_MUL(BOOT_MUL), .BOOT_ADD(BOOT_ADD)) u_core (
        .clk(clk), .rst_n(rst_n),
        .a_en(h_en), .a_wr(h_wr), .a_idx(h_idx), .a_wword(h_merged), .a_cur(h_cur), .a_q(h_q),
        .b_en(i_en), .b_wr(i_we), .b_idx(i_idx), .b_wword(i_wdata), .b_q(i_q)
    );

    assign i_rdata = i_q;

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        h_en |=> (h_rdata[31:18] == 14'd0));
    p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (h_rdata == 32'd0 && i_rdata == 18'd0));
endmodule

// File: tb/tb_dual_port_prog_mem.sv
`timescale 1ns/1ps
module tb_dual_port_prog_mem;
    localparam int D = 64;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        h_en = 0;
    logic [3:0]  h_be = 0;
    logic [31:0] h_addr = 0, h_wdata = 0;
    logic [31:0] h_rdata;
    logic        i_en = 0, i_we = 0;
    logic [31:0] i_addr = 0;
    logic [17:0] i_wdata = 0;
    logic [17:0] i_rdata;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [17:0] model [D];

    always #2.5 clk = ~clk;

    dual_port_prog_mem #(.DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .h_en(h_en), .h_be(h_be), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .i_en(i_en), .i_we(i_we),
        .i_addr(i_addr), .i_wdata(i_wdata), .i_rdata(i_rdata)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] merge(logic [17:0] old, logic [3:0] be, logic [31:0] wd);
        logic [17:0] r = old;
        if (be[0]) r[7:0]   = wd[7:0];
        if (be[1]) r[15:8]  = wd[15:8];
        if (be[2]) r[17:16] = wd[17:16];
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < D; i++) model[i] = 18'((i * 37 + 5) % 262144);
        #1;
        h_en = 1; i_en = 1; h_addr = 8; i_addr = 12;
        repeat (3) tick();
        // R9: reset clears read registers
        chk("R9 reset h_rdata", h_rdata, 0);
        chk("R9 reset i_rdata", {14'd0, i_rdata}, 0);
        rst_n = 1;

        // R1 R7 R2 R3: boot image sweep with stray low bits, both ports
        for (int i = 0; i < D; i++) begin
            h_addr = i * 4 + (i % 4);
            i_addr = i * 4 + ((i + 1) % 4);
            tick();
            chk("R1 R7 boot i_rdata", {14'd0, i_rdata}, {14'd0, model[i]});
            chk("R3 R2 boot h_rdata", h_rdata, {14'd0, model[i]});
        end
        // R2: high bits ignored, wrap
        for (int i = 0; i < D; i += 7) begin
            h_addr = 32'h8000_0000 | ((i + D) * 4) | 3;
            i_addr = ((i + 3 * D) * 4) | 1;
            tick();
            chk("R2 wrap h", h_rdata, {14'd0, model[i]});
            chk("R2 wrap i", {14'd0, i_rdata}, {14'd0, model[i]});
        end

        // R4 R5: all byte-enable patterns on word 10
        i_en = 0;
        for (int p = 0; p < 16; p++) begin
            logic [31:0] wd;
            wd = 32'hFFFF_0000 ^ (32'h0001_2345 * (p + 1));
            h_addr = 10 * 4; h_be = 4'(p); h_wdata = wd;
            model[10] = merge(model[10], 4'(p), wd);
            tick();
            chk("R5 write-first", h_rdata, {14'd0, model[10]});
            h_be = 0;
            tick();
            chk("R4 byte enable readback", h_rdata, {14'd0, model[10]});
        end

        // R6: instruction write returns old data, R10 host sees new
        h_en = 0; i_en = 1; i_we = 1; i_addr = 20 * 4; i_wdata = 18'h2_A5C3;
        tick();
        chk("R6 read-first", {14'd0, i_rdata}, {14'd0, model[20]});
        model[20] = 18'h2_A5C3;
        i_we = 0; i_en = 0; h_en = 1; h_addr = 20 * 4;
        tick();
        chk("R10 host sees instr write", h_rdata, {14'd0, model[20]});
        i_en = 1; i_addr = 20 * 4;
        tick();
        chk("R6 new value after write", {14'd0, i_rdata}, {14'd0, model[20]});

        // R10: host write then instruction read
        h_addr = 30 * 4; h_be = 4'b0111; h_wdata = 32'h0003_1111;
        i_addr = 5 * 4;
        tick();
        model[30] = 18'h3_1111;
        h_be = 0; i_addr = 30 * 4;
        tick();
        chk("R10 instr sees host write", {14'd0, i_rdata}, {14'd0, model[30]});

        // R8: disabled ports hold and do not write
        h_en = 0; i_en = 0; h_addr = 40 * 4; h_be = 4'hF; h_wdata = 32'h1234;
        i_addr = 41 * 4; i_we = 1; i_wdata = 18'h1_0101;
        tick(); tick();
        chk("R8 host hold", h_rdata, {14'd0, model[30]});
        chk("R8 instr hold", {14'd0, i_rdata}, {14'd0, model[30]});
        h_en = 1; h_be = 0; i_en = 1; i_we = 0;
        tick();
        chk("R8 no host write", h_rdata, {14'd0, model[40]});
        chk("R8 no instr write", {14'd0, i_rdata}, {14'd0, model[41]});

        // R9: mid-run reset clears outputs, keeps contents, blocks writes
        rst_n = 0; h_addr = 50 * 4; h_be = 4'h7; h_wdata = 32'h3FFFF;
        tick();
        chk("R9 mid reset h", h_rdata, 0);
        chk("R9 mid reset i", {14'd0, i_rdata}, 0);
        rst_n = 1; h_be = 0; i_addr = 30 * 4;
        tick();
        chk("R9 contents kept", {14'd0, i_rdata}, {14'd0, model[30]});
        chk("R9 no write in reset", h_rdata, {14'd0, model[50]});

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule